// File: doc/BRIEF.md
# Loopback Round-Trip Latency Probe

The block sits between the receive and transmit stream FIFOs of a host-fed loopback path. While no measurement runs, every word accepted on the stream input goes out on the stream output unchanged, in the same cycle. The host keeps sending a buffer filled with one constant value, the background word. This traffic circulates through host memory and comes back to the block.

To take a measurement, the host pulses `start`. The block then sends out one marker word that differs from the background value. The marker waits for output ready like any other word. In the cycle the marker is handed off, a cycle counter begins. Once the counter is running, the first accepted input word that does not equal the background word stops it. The host then reads `lat_count` and multiplies it by the clock period to get the round-trip time. At a 250 MHz clock, one count is 4 ns.

The counter saturates instead of wrapping. When it saturates, the measurement ends and a sticky timeout flag is set.

Top module: `rtt_probe`

## Requirements
- R1: Reset is synchronous and active high. It leaves `lat_count` at 0 and `done`, `timeout` and `busy` all low.
- R2: When not busy, the output follows the input in the same cycle: `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`.
- R3: A `start` pulse while not busy has the following effect from the next cycle on:
  - `busy` is high.
  - `out_valid` is 1 and `out_data` carries `marker_word`.
  - `in_ready` is 0.
- R4: The marker is held on the output with `in_ready` low for as long as `out_ready` is low. After the marker is handed off, pass-through resumes. No input word is lost or repeated.
- R5: `lat_count` is 0 after the edge on which the marker is handed off. It then rises by one on each later edge, up to and including the edge on which the returning word is accepted. A return accepted k cycles after the marker therefore reads k.
- R6: Only words that are accepted (`in_valid` and `in_ready` both high) and that differ from `bg_word` end a measurement. Background words, and differing words offered while `out_ready` is low, leave it running.
- R7: When a measurement ends, `done` rises, `busy` falls and `lat_count` holds its value.
- R8: `done` stays high until a cycle with `done_clr` high. After that cycle it reads 0, and `lat_count` is kept.
- R9: A `start` pulse while busy is ignored. The count keeps rising and no new marker is sent.
- R10: The count stops at all ones (2^CW−1, which is 255 for CW=8). On the edge where it reaches that value, the measurement ends with `done` and `timeout` both high. After that the count stays at all ones.
- R11: An accepted `start` clears `done`, `timeout` and `lat_count` to 0, even if `done` was still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive FIFO has a word |
| in_data | input | DW | Receive FIFO word |
| in_ready | output | 1 | Block takes the receive word this cycle |
| out_valid | output | 1 | Word offered to the transmit FIFO |
| out_data | output | DW | Word offered to the transmit FIFO |
| out_ready | input | 1 | Transmit FIFO accepts the word this cycle |
| start | input | 1 | Pulse to begin a measurement |
| marker_word | input | DW | Word injected as the marker (captured at start) |
| bg_word | input | DW | Background value that circulating traffic carries |
| done_clr | input | 1 | Clears the done flag |
| lat_count | output | CW | Measured cycle count |
| done | output | 1 | Measurement finished (sticky) |
| timeout | output | 1 | Count saturated (sticky until next start) |
| busy | output | 1 | Marker pending or measurement running |

## Verification
The pass-through path is driven with a set of idle vectors. These pair valid high or low with ready high or low across several data words, which separates correct valid and ready forwarding from any coupling between the two directions.

Measurements are tried with four patterns:
- A marker held under backpressure, showing that the hold does not add to the count.
- A run of background words followed by a differing word first refused and then accepted, which tells content matching apart from handshake matching.
- A marker that returns one cycle after hand-off.
- A marker that never returns, which exercises saturation at the narrow counter width used on the bench.

// File: rtl/rtt_probe_pkg.sv
package rtt_probe_pkg;

    // Measurement phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_INJECT = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;

    // Result flags seen by the host
    typedef struct packed {
        logic done;
        logic timeout;
    } flags_t;

    localparam int DEF_DW = 32;
    localparam int DEF_CW = 32;

    function automatic logic phase_busy(input phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/rtt_stream_mux.sv
module rtt_stream_mux
    import rtt_probe_pkg::*;
#(
    parameter int DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic          load_marker,
    input  logic [DW-1:0] marker_word,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          marker_fire,
    output logic          in_accept
);

    logic [DW-1:0] marker_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            marker_q <= '0;
        end else if (load_marker) begin
            marker_q <= marker_word;
        end
    end

    always_comb begin
        if (phase == PH_INJECT) begin
            out_valid = 1'b1;
            out_data  = marker_q;
            in_ready  = 1'b0;
        end else begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
        end
    end

    assign marker_fire = (phase == PH_INJECT) && out_ready;
    assign in_accept   = in_valid && in_ready;

endmodule

// File: rtl/rtt_ret_detect.sv
module rtt_ret_detect
    import rtt_probe_pkg::*;
#(
    parameter int DW = DEF_DW
) (
    input  phase_e        phase,
    input  logic          in_accept,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] bg_word,
    output logic          hit
);

    logic differs;

    assign differs = |(in_data ^ bg_word);
    assign hit     = (phase == PH_WAIT) && in_accept && differs;

endmodule

// File: rtl/rtt_timer.sv
module rtt_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] count,
    output logic          will_sat
);

    localparam logic [CW-1:0] TOP  = '1;
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] LAST = TOP - ONE;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en && (count != TOP)) begin
            count <= count + ONE;
        end
    end

    assign will_sat = en && (count == LAST);

endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
    import rtt_probe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   marker_fire,
    input  logic   hit,
    input  logic   will_sat,
    input  logic   done_clr,
    output phase_e phase,
    output flags_t flags,
    output logic   tmr_clr,
    output logic   tmr_en
);

    phase_e phase_n;
    logic   arm_ok;
    logic   stop;

    assign arm_ok  = start && (phase == PH_IDLE);
    assign stop    = (phase == PH_WAIT) && (hit || will_sat);
    assign tmr_clr = arm_ok;
    assign tmr_en  = (phase == PH_WAIT);

    always_comb begin
        phase_n = phase;
        unique case (phase)
            PH_IDLE:   if (arm_ok)      phase_n = PH_INJECT;
            PH_INJECT: if (marker_fire) phase_n = PH_WAIT;
            PH_WAIT:   if (stop)        phase_n = PH_IDLE;
            default:                    phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            flags <= '0;
        end else begin
            phase <= phase_n;
            if (arm_ok) begin
                flags <= '0;
            end else if (stop) begin
                flags.done    <= 1'b1;
                flags.timeout <= will_sat;
            end else if (done_clr) begin
                flags.done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtt_probe.sv
module rtt_probe
    import rtt_probe_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int CW = DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    input  logic          start,
    input  logic [DW-1:0] marker_word,
    input  logic [DW-1:0] bg_word,
    input  logic          done_clr,
    output logic [CW-1:0] lat_count,
    output logic          done,
    output logic          timeout,
    output logic          busy
);

    phase_e phase;
    flags_t flags;
    logic   tmr_clr;
    logic   tmr_en;
    logic   will_sat;
    logic   marker_fire;
    logic   in_accept;
    logic   hit;

    rtt_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .marker_fire (marker_fire),
        .hit         (hit),
        .will_sat    (will_sat),
        .done_clr    (done_clr),
        .phase       (phase),
        .flags       (flags),
        .tmr_clr     (tmr_clr),
        .tmr_en      (tmr_en)
    );

    rtt_stream_mux #(.DW(DW)) u_mux (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .load_marker (tmr_clr),
        .marker_word (marker_word),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready),
        .marker_fire (marker_fire),
        .in_accept   (in_accept)
    );

    rtt_ret_detect #(.DW(DW)) u_det (
        .phase     (phase),
        .in_accept (in_accept),
        .in_data   (in_data),
        .bg_word   (bg_word),
        .hit       (hit)
    );

    rtt_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .en       (tmr_en),
        .count    (lat_count),
        .will_sat (will_sat)
    );

    assign done    = flags.done;
    assign timeout = flags.timeout;
    assign busy    = phase_busy(phase);

endmodule

// File: rtl/rtt_probe_chk.sv
module rtt_probe_chk
    import rtt_probe_pkg::*;
#(
    parameter int DW = DEF_DW,
    parameter int CW = DEF_CW
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          in_ready,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_ready,
    input logic          start,
    input logic          done_clr,
    input logic [CW-1:0] lat_count,
    input logic          done,
    input logic          timeout,
    input logic          busy,
    input phase_e        phase
);

    localparam logic [CW-1:0] TOP = '1;

    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (out_valid == in_valid) && (out_data == in_data) && (in_ready == out_ready));

    assert_arm_start_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (out_valid && busy && !done && lat_count == '0));

    assert_marker_held_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INJECT && !out_ready) |=> (out_valid && !in_ready && out_data == $past(out_data)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && lat_count != TOP) |=> (lat_count == $past(lat_count) + 1'b1));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (done && done_clr) |=> !done);

    assert_rearm_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && start) |=> (lat_count != '0));

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (lat_count == TOP && !start) |=> (lat_count == TOP));

    assert_timeout_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> (done && lat_count == TOP));

endmodule

bind rtt_probe rtt_probe_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .start     (start),
    .done_clr  (done_clr),
    .lat_count (lat_count),
    .done      (done),
    .timeout   (timeout),
    .busy      (busy),
    .phase     (phase)
);

// File: tb/rtt_probe_test.sv
module rtt_probe_test;

    localparam int DW = 16;
    localparam int CW = 8;
    localparam logic [DW-1:0] BG   = 16'h5A5A;
    localparam logic [DW-1:0] MARK = 16'hC3C3;

    // {in_valid, out_ready, in_data, exp_out_valid, exp_in_ready}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b1, 16'h5A5A, 1'b1, 1'b1},
        {1'b1, 1'b0, 16'h5A5A, 1'b1, 1'b0},
        {1'b0, 1'b1, 16'h1234, 1'b0, 1'b1},
        {1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0},
        {1'b1, 1'b1, 16'hC3C3, 1'b1, 1'b1},
        {1'b1, 1'b1, 16'h0000, 1'b1, 1'b1},
        {1'b1, 1'b0, 16'hA5A5, 1'b1, 1'b0},
        {1'b0, 1'b1, 16'h8001, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready;
    logic          start;
    logic          done_clr;
    logic [CW-1:0] lat_count;
    logic          done;
    logic          timeout;
    logic          busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rtt_probe #(.DW(DW), .CW(CW)) uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready),
        .start       (start),
        .marker_word (MARK),
        .bg_word     (BG),
        .done_clr    (done_clr),
        .lat_count   (lat_count),
        .done        (done),
        .timeout     (timeout),
        .busy        (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        start = 1'b0; done_clr = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 count", 32'(lat_count), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 timeout", 32'(timeout), 0);
        chk("R1 busy", 32'(busy), 0);

        // R2 idle pass-through vectors
        for (int i = 0; i < NV; i++) begin
            in_valid  = VEC[i][19];
            out_ready = VEC[i][18];
            in_data   = VEC[i][17:2];
            #1;
            chk("R2 out_valid", 32'(out_valid), 32'(VEC[i][1]));
            chk("R2 out_data", 32'(out_data), 32'(VEC[i][17:2]));
            chk("R2 in_ready", 32'(in_ready), 32'(VEC[i][0]));
            step();
        end

        // Measurement with backpressure on the marker
        in_valid = 1'b0; out_ready = 1'b1; start = 1'b1;
        step();
        start = 1'b0; #1;
        chk("R3 out_valid", 32'(out_valid), 1);
        chk("R3 out_data", 32'(out_data), 32'(MARK));
        chk("R3 in_ready", 32'(in_ready), 0);
        chk("R3 busy", 32'(busy), 1);
        chk("R11 count cleared", 32'(lat_count), 0);
        out_ready = 1'b0; in_valid = 1'b1; in_data = BG;
        step(); #1;
        chk("R4 marker held", 32'(out_data), 32'(MARK));
        chk("R4 in_ready low", 32'(in_ready), 0);
        step(); #1;
        chk("R4 marker held 2", 32'(out_valid), 1);
        chk("R4 count idle during hold", 32'(lat_count), 0);
        out_ready = 1'b1; #1;
        chk("R4 input not taken with marker", 32'(in_ready), 0);
        step(); #1;  // marker handed off
        chk("R4 pass resumes data", 32'(out_data), 32'(BG));
        chk("R4 pass resumes ready", 32'(in_ready), 1);
        chk("R5 count zero at handoff", 32'(lat_count), 0);
        step();
        chk("R5 count 1", 32'(lat_count), 1);
        start = 1'b1;
        step();
        start = 1'b0; #1;
        chk("R9 rearm ignored count", 32'(lat_count), 2);
        chk("R9 rearm no marker", 32'(out_data), 32'(BG));
        step();
        chk("R6 background no stop", 32'(busy), 1);
        chk("R6 count 3", 32'(lat_count), 3);
        in_data = MARK; out_ready = 1'b0;
        step();
        chk("R6 refused word no stop", 32'(busy), 1);
        chk("R6 count 4", 32'(lat_count), 4);
        out_ready = 1'b1;
        step();
        in_valid = 1'b0;
        chk("R5 count at return", 32'(lat_count), 5);
        chk("R7 done", 32'(done), 1);
        chk("R7 busy low", 32'(busy), 0);
        chk("R7 no timeout", 32'(timeout), 0);
        step(); step();
        chk("R8 done sticky", 32'(done), 1);
        chk("R7 count held", 32'(lat_count), 5);
        done_clr = 1'b1;
        step();
        done_clr = 1'b0;
        chk("R8 done cleared", 32'(done), 0);
        chk("R8 count kept", 32'(lat_count), 5);

        // Immediate return
        start = 1'b1;
        step();
        start = 1'b0;
        in_valid = 1'b1; in_data = MARK; out_ready = 1'b1;
        step();  // marker handed off, input blocked this edge
        chk("R5 handoff count", 32'(lat_count), 0);
        step();
        in_valid = 1'b0;
        chk("R5 one-cycle return", 32'(lat_count), 1);
        chk("R7 done after return", 32'(done), 1);

        // Re-arm with done still set, then saturate
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R11 done cleared by start", 32'(done), 0);
        chk("R11 count cleared by start", 32'(lat_count), 0);
        step();  // marker handed off
        repeat (254) step();
        chk("R10 count before sat", 32'(lat_count), 254);
        chk("R10 busy before sat", 32'(busy), 1);
        chk("R10 no timeout yet", 32'(timeout), 0);
        step();
        chk("R10 count saturated", 32'(lat_count), 255);
        chk("R10 timeout", 32'(timeout), 1);
        chk("R10 done", 32'(done), 1);
        chk("R10 ended", 32'(busy), 0);
        step();
        chk("R10 count stays", 32'(lat_count), 255);
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R11 timeout cleared", 32'(timeout), 0);
        chk("R11 count restarts", 32'(lat_count), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule